// File: doc/BRIEF.md
# Compressed Parcel Field Decoder

This block decodes one 16-bit compressed instruction parcel into the operand fields an execution pipeline needs: an operation code, three 3-bit register numbers, flags that mark an operand as the constant zero, a condition-register target, an auxiliary function field, a condition-bit index, a link flag, a signed byte offset for branches and an illegal-instruction flag. A mode input picks between the narrow sub-mode, in which only the low ten bits carry meaning for most groups, and the wide sub-mode, in which the top bits widen register numbers and offsets. The same parcel therefore decodes differently in each sub-mode. The differences are implicit destinations, narrower register fields, and opcodes that are legal in only one of the two.

The decode is purely combinational and split into three group decoders: register-to-register arithmetic, flow and memory, and condition/special-register. A single output register stage follows them. A parcel presented with `in_valid` high appears on the outputs, with `out_valid` high, on the next clock edge. While `in_valid` is low the outputs hold and `out_valid` is low.

Top module: `cparcel_decoder`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. The decoded fields are captured only on a clock edge where `in_valid` is high and hold otherwise. Reset (`rst_n` low) clears every output to zero.
- R2: With P = `in_parcel`, the group is P[10:8], and P[0] must be 1 or the parcel is illegal. `out_op` codes: 0 illegal, 1 branch, 2 branch-to-link-register, 3 branch-to-target-register, 4 fp load, 5 fp store, 6 load, 7 store, 8 add, 9 mul, 10 sub, 11 neg, 12 and, 13 nand, 14 or, 15 nor, 16 not, 17 sign-extend, 18 count-leading-zeros, 19 population-count, 20 fadd, 21 fmul, 22 fsub, 23 fneg, 24 fabs, 25 fmove, 26 CR-field move, 27 CR logical, 28 move to special register, 29 move from special register.
- R3: For groups 010 to 110: `out_rb`=P[7:5] and `out_ra`=P[4:2]. `out_rt` is P[13:11] in the wide sub-mode (`in_mode16`=1) and equals P[7:5] in the narrow sub-mode.
- R4: In groups 010 to 110, P[4:2]=000 sets `out_ra_zero`. In that case group 011 gives neg (P[1]=0) or fneg (P[1]=1), group 100 gives sign-extend/count-leading-zeros, group 101 gives population-count (P[1]=0) or not (P[1]=1), and group 110 gives fabs or fmove. Otherwise P[1] picks add/mul, sub/fsub, and/nand, or/nor and fadd/fmul.
- R5: Sign-extend, count-leading-zeros, population-count and fmove are illegal in the narrow sub-mode.
- R6: `out_crt` is 01 (CR0) for sub and neg, 10 (CR1) for fsub, fneg and fmove, and 00 otherwise.
- R7: Group 111: P[1]=0 is load and P[1]=1 is store. Wide: load rt=P[13:11], ra=P[7:5], rb=P[4:2]; store rb=P[13:11], ra=P[7:5], rt=P[4:2]. Narrow: ra={0,P[6:5]}; a load has rb={0,P[3:2]} and rt=rb; a store has rt={0,P[3:2]}, rb=0 and `out_rb_zero`=1.
- R8: Group 001 with P[7]=1 and P[4]=1 is an fp load (P[1]=0: rt=P[13:11], ra={P[14],P[6:5]}, rb={P[15],P[3:2]}) or an fp store (P[1]=1: rb=P[13:11], ra={P[15],P[6:5]}, rt={P[14],P[3:2]}). Both are illegal in the narrow sub-mode.
- R9: Group 000 is a branch with `out_link`=P[1]. `out_offs` is a 9-bit two's-complement byte offset equal to twice the signed value of P[7:2] (narrow) or of {P[15:14],P[7:2]} (wide).
- R10: Group 001 with P[7]=0 branches to the link register (P[4]=0) or to the target register (P[4]=1), with `out_link`=P[1]. `out_aux` holds the branch options: {00,P[3:2]} narrow, {P[15:14],P[3:2]} wide. In it, bit 1 enables the condition test and bit 0 inverts it. `out_bi` is {000,P[6:5]} narrow and {P[13:11],P[6:5]} wide.
- R11: Group 001 with P[7]=1, P[4]=0 and sub-opcode S=P[15:12] equal to 0000 is a CR-field move: rt={P[11],P[6:5]} (wide) or {0,P[6:5]} (narrow), ra=P[3:1]. S in {0001,0100,0110,0111,1000,1001,1101,1110} is CR logical: rt=ra={P[11],P[6:5]}, rb=P[3:1], `out_aux`=S. It is illegal in the narrow sub-mode.
- R12: S=1111 is a special-register move: P[11]=0 is move-to and 1 is move-from, rt=P[3:1], and `out_aux`={00,P[6:5]} selects 0 link, 1 count, 2 target, 3 condition register. It is illegal in the narrow sub-mode.
- R13: S in {0010,0011,0101,1010,1011,1100} is illegal. Every illegal parcel gives `out_illegal`=1 with all other decoded outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Parcel strobe |
| in_parcel | input | 16 | Compressed parcel |
| in_mode16 | input | 1 | 1 = wide sub-mode, 0 = narrow sub-mode |
| out_valid | output | 1 | Decoded result strobe |
| out_op | output | 5 | Operation code |
| out_rt | output | 3 | Destination / data register |
| out_ra | output | 3 | First source register |
| out_rb | output | 3 | Second source register |
| out_ra_zero | output | 1 | A operand is constant zero |
| out_rb_zero | output | 1 | B operand absent (no offset) |
| out_crt | output | 2 | Condition-register target |
| out_aux | output | 4 | Branch options, CR function or special-register select |
| out_bi | output | 5 | Condition bit index for register branches |
| out_link | output | 1 | Branch writes the link register |
| out_offs | output | 9 | Signed branch byte offset |
| out_illegal | output | 1 | Illegal parcel |

## Verification
The bench builds the decoder with its default `TAIL_CHECK`=1, so the marker bit takes part in the legality rule. It sweeps all 65,536 parcel values in both sub-modes back to back, which reaches every group, every sub-opcode, every zero-register case and both signs of every offset. Each result is compared against a decode computed bit by bit from the requirements. Separate steps check the reset values and the hold behaviour while the strobe is low.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    localparam int PARCEL_W = 16;
    localparam int REG_W    = 3;
    localparam int AUX_W    = 4;
    localparam int BI_W     = 5;
    localparam int OFFS_W   = 9;
    localparam int OP_W     = 5;
    localparam int CRT_W    = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ILL       = 5'd0,
        OP_BR        = 5'd1,
        OP_BR_LREG   = 5'd2,
        OP_BR_TREG   = 5'd3,
        OP_FLOAD     = 5'd4,
        OP_FSTORE    = 5'd5,
        OP_LOAD      = 5'd6,
        OP_STORE     = 5'd7,
        OP_ADD       = 5'd8,
        OP_MUL       = 5'd9,
        OP_SUB       = 5'd10,
        OP_NEG       = 5'd11,
        OP_AND       = 5'd12,
        OP_NAND      = 5'd13,
        OP_OR        = 5'd14,
        OP_NOR       = 5'd15,
        OP_NOT       = 5'd16,
        OP_SEXT      = 5'd17,
        OP_CLZ       = 5'd18,
        OP_POPC      = 5'd19,
        OP_FADD      = 5'd20,
        OP_FMUL      = 5'd21,
        OP_FSUB      = 5'd22,
        OP_FNEG      = 5'd23,
        OP_FABS      = 5'd24,
        OP_FMOVE     = 5'd25,
        OP_CRMOVE    = 5'd26,
        OP_CRLOGIC   = 5'd27,
        OP_TOSPR     = 5'd28,
        OP_FROMSPR   = 5'd29
    } op_e;

    localparam logic [CRT_W-1:0] CRT_NONE = 2'd0;
    localparam logic [CRT_W-1:0] CRT_CR0  = 2'd1;
    localparam logic [CRT_W-1:0] CRT_CR1  = 2'd2;

    typedef struct packed {
        op_e               op;
        logic [REG_W-1:0]  rt;
        logic [REG_W-1:0]  ra;
        logic [REG_W-1:0]  rb;
        logic              raz;
        logic              rbz;
        logic [CRT_W-1:0]  crt;
        logic [AUX_W-1:0]  aux;
        logic [BI_W-1:0]   bi;
        logic              link;
        logic [OFFS_W-1:0] offs;
        logic              ill;
    } dec_t;

endpackage

// File: rtl/cpd_alu_dec.sv
module cpd_alu_dec
    import cpd_pkg::*;
(
    input  logic             mode16,
    input  logic [2:0]       grp,
    input  logic [REG_W-1:0] rt_x,
    input  logic [REG_W-1:0] fb,
    input  logic [REG_W-1:0] fa,
    input  logic             xbit,
    output dec_t             dec
);

    logic unary;
    assign unary = (fa == '0);

    always_comb begin
        dec     = '0;
        dec.rt  = mode16 ? rt_x : fb;
        dec.rb  = fb;
        dec.ra  = fa;
        dec.raz = unary;
        unique case (grp)
            3'b010: begin
                dec.op = xbit ? OP_MUL : OP_ADD;
            end
            3'b011: begin
                if (!xbit) begin
                    dec.op  = unary ? OP_NEG : OP_SUB;
                    dec.crt = CRT_CR0;
                end else begin
                    dec.op  = unary ? OP_FNEG : OP_FSUB;
                    dec.crt = CRT_CR1;
                end
            end
            3'b100: begin
                if (unary) begin
                    dec.op  = xbit ? OP_CLZ : OP_SEXT;
                    dec.ill = !mode16;
                end else begin
                    dec.op  = xbit ? OP_NAND : OP_AND;
                end
            end
            3'b101: begin
                if (unary) begin
                    if (xbit) begin
                        dec.op = OP_NOT;
                    end else begin
                        dec.op  = OP_POPC;
                        dec.ill = !mode16;
                    end
                end else begin
                    dec.op = xbit ? OP_NOR : OP_OR;
                end
            end
            3'b110: begin
                if (unary) begin
                    if (xbit) begin
                        dec.op  = OP_FMOVE;
                        dec.crt = CRT_CR1;
                        dec.ill = !mode16;
                    end else begin
                        dec.op = OP_FABS;
                    end
                end else begin
                    dec.op = xbit ? OP_FMUL : OP_FADD;
                end
            end
            default: begin
                dec.ill = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cpd_flow_dec.sv
module cpd_flow_dec
    import cpd_pkg::*;
(
    input  logic             mode16,
    input  logic [2:0]       grp,
    input  logic [1:0]       hi2,
    input  logic [REG_W-1:0] rt_x,
    input  logic [REG_W-1:0] fb,
    input  logic [REG_W-1:0] fa,
    input  logic             xbit,
    output dec_t             dec
);

    logic [OFFS_W-1:0] offs_narrow;
    logic [OFFS_W-1:0] offs_wide;

    assign offs_narrow = {{2{fb[2]}}, fb, fa, 1'b0};
    assign offs_wide   = {hi2, fb, fa, 1'b0};

    always_comb begin
        dec = '0;
        unique case (grp)
            3'b000: begin
                dec.op   = OP_BR;
                dec.link = xbit;
                dec.offs = mode16 ? offs_wide : offs_narrow;
            end
            3'b001: begin
                if (!fb[2]) begin
                    dec.op   = fa[2] ? OP_BR_TREG : OP_BR_LREG;
                    dec.link = xbit;
                    if (mode16) begin
                        dec.bi  = {rt_x, fb[1:0]};
                        dec.aux = {hi2, fa[1:0]};
                    end else begin
                        dec.bi  = {3'b000, fb[1:0]};
                        dec.aux = {2'b00, fa[1:0]};
                    end
                end else if (fa[2]) begin
                    if (!mode16) begin
                        dec.ill = 1'b1;
                    end else if (!xbit) begin
                        dec.op = OP_FLOAD;
                        dec.rt = rt_x;
                        dec.ra = {hi2[0], fb[1:0]};
                        dec.rb = {hi2[1], fa[1:0]};
                    end else begin
                        dec.op = OP_FSTORE;
                        dec.rb = rt_x;
                        dec.ra = {hi2[1], fb[1:0]};
                        dec.rt = {hi2[0], fa[1:0]};
                    end
                end else begin
                    dec.ill = 1'b1;
                end
            end
            3'b111: begin
                if (mode16) begin
                    dec.ra = fb;
                    if (!xbit) begin
                        dec.op = OP_LOAD;
                        dec.rt = rt_x;
                        dec.rb = fa;
                    end else begin
                        dec.op = OP_STORE;
                        dec.rb = rt_x;
                        dec.rt = fa;
                    end
                end else begin
                    dec.ra = {1'b0, fb[1:0]};
                    if (!xbit) begin
                        dec.op = OP_LOAD;
                        dec.rb = {1'b0, fa[1:0]};
                        dec.rt = {1'b0, fa[1:0]};
                    end else begin
                        dec.op  = OP_STORE;
                        dec.rt  = {1'b0, fa[1:0]};
                        dec.rbz = 1'b1;
                    end
                end
            end
            default: begin
                dec.ill = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cpd_sys_dec.sv
module cpd_sys_dec
    import cpd_pkg::*;
(
    input  logic             mode16,
    input  logic [3:0]       subop,
    input  logic             b4,
    input  logic [1:0]       fb_lo,
    input  logic [REG_W-1:0] bb,
    output dec_t             dec
);

    always_comb begin
        dec = '0;
        unique case (subop)
            4'b0000: begin
                dec.op = OP_CRMOVE;
                dec.rt = {mode16 & b4, fb_lo};
                dec.ra = bb;
            end
            4'b0001, 4'b0100, 4'b0110, 4'b0111,
            4'b1000, 4'b1001, 4'b1101, 4'b1110: begin
                dec.op  = OP_CRLOGIC;
                dec.rt  = {b4, fb_lo};
                dec.ra  = {b4, fb_lo};
                dec.rb  = bb;
                dec.aux = subop;
                dec.ill = !mode16;
            end
            4'b1111: begin
                dec.op  = b4 ? OP_FROMSPR : OP_TOSPR;
                dec.rt  = bb;
                dec.aux = {2'b00, fb_lo};
                dec.ill = !mode16;
            end
            default: begin
                dec.ill = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cparcel_decoder.sv
module cparcel_decoder
    import cpd_pkg::*;
#(
    parameter bit TAIL_CHECK = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [PARCEL_W-1:0] in_parcel,
    input  logic                in_mode16,
    output logic                out_valid,
    output logic [OP_W-1:0]     out_op,
    output logic [REG_W-1:0]    out_rt,
    output logic [REG_W-1:0]    out_ra,
    output logic [REG_W-1:0]    out_rb,
    output logic                out_ra_zero,
    output logic                out_rb_zero,
    output logic [CRT_W-1:0]    out_crt,
    output logic [AUX_W-1:0]    out_aux,
    output logic [BI_W-1:0]     out_bi,
    output logic                out_link,
    output logic [OFFS_W-1:0]   out_offs,
    output logic                out_illegal
);

    logic [2:0]       grp;
    logic [REG_W-1:0] fld_rtx;
    logic [REG_W-1:0] fld_b;
    logic [REG_W-1:0] fld_a;
    logic             tail_bad;

    assign grp     = in_parcel[10:8];
    assign fld_rtx = in_parcel[13:11];
    assign fld_b   = in_parcel[7:5];
    assign fld_a   = in_parcel[4:2];

    generate
        if (TAIL_CHECK) begin : g_tail
            assign tail_bad = ~in_parcel[0];
        end else begin : g_notail
            assign tail_bad = 1'b0;
        end
    endgenerate

    dec_t alu_dec, flow_dec, sys_dec, raw_dec, next_dec, dec_q;
    logic vld_q;

    cpd_alu_dec i_alu (
        .mode16 (in_mode16),
        .grp    (grp),
        .rt_x   (fld_rtx),
        .fb     (fld_b),
        .fa     (fld_a),
        .xbit   (in_parcel[1]),
        .dec    (alu_dec)
    );

    cpd_flow_dec i_flow (
        .mode16 (in_mode16),
        .grp    (grp),
        .hi2    (in_parcel[15:14]),
        .rt_x   (fld_rtx),
        .fb     (fld_b),
        .fa     (fld_a),
        .xbit   (in_parcel[1]),
        .dec    (flow_dec)
    );

    cpd_sys_dec i_sys (
        .mode16 (in_mode16),
        .subop  (in_parcel[15:12]),
        .b4     (in_parcel[11]),
        .fb_lo  (in_parcel[6:5]),
        .bb     (in_parcel[3:1]),
        .dec    (sys_dec)
    );

    always_comb begin
        unique case (grp)
            3'b000, 3'b111: raw_dec = flow_dec;
            3'b001:         raw_dec = (fld_b[2] && !fld_a[2]) ? sys_dec : flow_dec;
            default:        raw_dec = alu_dec;
        endcase
    end

    always_comb begin
        if (raw_dec.ill || tail_bad) begin
            next_dec     = '0;
            next_dec.ill = 1'b1;
        end else begin
            next_dec = raw_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dec_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                dec_q <= next_dec;
            end
        end
    end

    assign out_valid   = vld_q;
    assign out_op      = dec_q.op;
    assign out_rt      = dec_q.rt;
    assign out_ra      = dec_q.ra;
    assign out_rb      = dec_q.rb;
    assign out_ra_zero = dec_q.raz;
    assign out_rb_zero = dec_q.rbz;
    assign out_crt     = dec_q.crt;
    assign out_aux     = dec_q.aux;
    assign out_bi      = dec_q.bi;
    assign out_link    = dec_q.link;
    assign out_offs    = dec_q.offs;
    assign out_illegal = dec_q.ill;

endmodule

// File: rtl/cparcel_decoder_chk.sv
module cparcel_decoder_chk
    import cpd_pkg::*;
#(
    parameter bit TAIL_CHECK = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [PARCEL_W-1:0] in_parcel,
    input logic                in_mode16,
    input logic                out_valid,
    input logic [OP_W-1:0]     out_op,
    input logic [REG_W-1:0]    out_rt,
    input logic [REG_W-1:0]    out_ra,
    input logic [REG_W-1:0]    out_rb,
    input logic                out_ra_zero,
    input logic                out_rb_zero,
    input logic [CRT_W-1:0]    out_crt,
    input logic                out_illegal
);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_op) && $stable(out_rt)
                       && $stable(out_ra) && $stable(out_rb) && $stable(out_illegal)));

    assert_tail_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (TAIL_CHECK && in_valid && !in_parcel[0]) |=> out_illegal);

    assert_narrow_forbidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode16) |=> !(out_op inside {OP_SEXT, OP_CLZ, OP_POPC, OP_FMOVE,
                                                      OP_FLOAD, OP_FSTORE, OP_CRLOGIC,
                                                      OP_TOSPR, OP_FROMSPR}));

    assert_cr_target_ops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_crt != CRT_NONE) |-> (out_op inside {OP_SUB, OP_NEG, OP_FSUB, OP_FNEG, OP_FMOVE}));

    assert_no_offset_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_rb_zero |-> (out_op == OP_STORE && out_rb == '0));

    assert_illegal_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_op == OP_ILL && out_rt == '0 && out_ra == '0 && out_rb == '0
                         && !out_ra_zero && !out_rb_zero && out_crt == CRT_NONE));

endmodule

bind cparcel_decoder cparcel_decoder_chk #(.TAIL_CHECK(TAIL_CHECK)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_parcel   (in_parcel),
    .in_mode16   (in_mode16),
    .out_valid   (out_valid),
    .out_op      (out_op),
    .out_rt      (out_rt),
    .out_ra      (out_ra),
    .out_rb      (out_rb),
    .out_ra_zero (out_ra_zero),
    .out_rb_zero (out_rb_zero),
    .out_crt     (out_crt),
    .out_illegal (out_illegal)
);

// File: tb/test_cparcel_decoder.sv
module test_cparcel_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_parcel = '0;
    logic        in_mode16 = 1'b0;
    logic        out_valid;
    logic [4:0]  out_op;
    logic [2:0]  out_rt, out_ra, out_rb;
    logic        out_ra_zero, out_rb_zero;
    logic [1:0]  out_crt;
    logic [3:0]  out_aux;
    logic [4:0]  out_bi;
    logic        out_link;
    logic [8:0]  out_offs;
    logic        out_illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cparcel_decoder i_cparcel_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_parcel(in_parcel),
        .in_mode16(in_mode16), .out_valid(out_valid), .out_op(out_op),
        .out_rt(out_rt), .out_ra(out_ra), .out_rb(out_rb),
        .out_ra_zero(out_ra_zero), .out_rb_zero(out_rb_zero), .out_crt(out_crt),
        .out_aux(out_aux), .out_bi(out_bi), .out_link(out_link),
        .out_offs(out_offs), .out_illegal(out_illegal)
    );

    function automatic int db(input logic [15:0] p, input int k);
        return int'(p[15-k]);
    endfunction

    function automatic int fld(input logic [15:0] p, input int first, input int n);
        int v = 0;
        for (int k = first; k < first + n; k++) v = v * 2 + db(p, k);
        return v;
    endfunction

    function automatic logic [37:0] actual_vec();
        return {out_op, out_rt, out_ra, out_rb, out_ra_zero, out_rb_zero, out_crt,
                out_aux, out_bi, out_link, out_offs, out_illegal};
    endfunction

    function automatic logic [37:0] model(input logic [15:0] p, input bit m16, output string tag);
        int op = 0, rt = 0, ra = 0, rb = 0, raz = 0, rbz = 0, crt = 0;
        int aux = 0, bi = 0, lk = 0, offs = 0, ill = 0;
        int g   = fld(p, 5, 3);
        int e   = db(p, 14);
        int fa  = fld(p, 11, 3);
        int fb  = fld(p, 8, 3);
        int rtx = fld(p, 2, 3);
        int s   = fld(p, 0, 4);
        int v;
        logic [37:0] r;
        tag = "R2";
        if (db(p, 15) == 0) begin
            ill = 1; tag = "R2";
        end else begin
            case (g)
                0: begin
                    tag = "R9"; op = 1; lk = e;
                    if (m16) begin
                        v = fld(p, 0, 2) * 64 + fld(p, 8, 6);
                        if (v >= 128) v -= 256;
                    end else begin
                        v = fld(p, 8, 6);
                        if (v >= 32) v -= 64;
                    end
                    offs = v * 2;
                end
                1: begin
                    if (db(p, 8) == 0) begin
                        tag = "R10"; op = db(p, 11) ? 3 : 2; lk = e;
                        bi  = m16 ? fld(p, 2, 3) * 4 + fld(p, 9, 2) : fld(p, 9, 2);
                        aux = m16 ? fld(p, 0, 2) * 4 + fld(p, 12, 2) : fld(p, 12, 2);
                    end else if (db(p, 11) == 1) begin
                        tag = "R8";
                        if (!m16) ill = 1;
                        else if (e == 0) begin
                            op = 4; rt = rtx;
                            ra = db(p, 1) * 4 + fld(p, 9, 2);
                            rb = db(p, 0) * 4 + fld(p, 12, 2);
                        end else begin
                            op = 5; rb = rtx;
                            ra = db(p, 0) * 4 + fld(p, 9, 2);
                            rt = db(p, 1) * 4 + fld(p, 12, 2);
                        end
                    end else if (s == 0) begin
                        tag = "R11"; op = 26;
                        rt = (m16 ? db(p, 4) * 4 : 0) + fld(p, 9, 2);
                        ra = fld(p, 12, 3);
                    end else if (s == 15) begin
                        tag = "R12"; ill = m16 ? 0 : 1;
                        op = db(p, 4) ? 29 : 28;
                        rt = fld(p, 12, 3); aux = fld(p, 9, 2);
                    end else if (s == 1 || s == 4 || s == 6 || s == 7 ||
                                 s == 8 || s == 9 || s == 13 || s == 14) begin
                        tag = "R11"; ill = m16 ? 0 : 1; op = 27;
                        rt = db(p, 4) * 4 + fld(p, 9, 2); ra = rt;
                        rb = fld(p, 12, 3); aux = s;
                    end else begin
                        tag = "R13"; ill = 1;
                    end
                end
                7: begin
                    tag = "R7";
                    if (m16) begin
                        ra = fb;
                        if (e == 0) begin op = 6; rt = rtx; rb = fa; end
                        else begin op = 7; rb = rtx; rt = fa; end
                    end else begin
                        ra = fld(p, 9, 2);
                        if (e == 0) begin op = 6; rb = fld(p, 12, 2); rt = rb; end
                        else begin op = 7; rt = fld(p, 12, 2); rbz = 1; end
                    end
                end
                default: begin
                    tag = "R3";
                    rt = m16 ? rtx : fb; rb = fb; ra = fa;
                    raz = (fa == 0) ? 1 : 0;
                    if (raz) tag = "R4";
                    case (g)
                        2: op = e ? 9 : 8;
                        3: begin
                            tag = "R6";
                            if (e == 0) begin op = raz ? 11 : 10; crt = 1; end
                            else begin op = raz ? 23 : 22; crt = 2; end
                        end
                        4: if (raz) begin op = e ? 18 : 17; tag = "R5"; ill = m16 ? 0 : 1; end
                           else op = e ? 13 : 12;
                        5: if (raz) begin
                               if (e) op = 16;
                               else begin op = 19; tag = "R5"; ill = m16 ? 0 : 1; end
                           end else op = e ? 15 : 14;
                        default: if (raz) begin
                               if (e) begin op = 25; crt = 2; tag = "R5"; ill = m16 ? 0 : 1; end
                               else op = 24;
                           end else op = e ? 21 : 20;
                    endcase
                end
            endcase
        end
        if (ill != 0) begin
            op = 0; rt = 0; ra = 0; rb = 0; raz = 0; rbz = 0; crt = 0;
            aux = 0; bi = 0; lk = 0; offs = 0;
            if (tag != "R5" && tag != "R2") tag = {tag, "/R13"};
        end
        r = {op[4:0], rt[2:0], ra[2:0], rb[2:0], raz[0], rbz[0], crt[1:0],
             aux[3:0], bi[4:0], lk[0], offs[8:0], ill[0]};
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [15:0] p, input bit m16,
                             input logic [37:0] exp_v);
        total++;
        if (out_valid !== 1'b1 || actual_vec() !== exp_v) begin
            bad++;
            $display("FAIL %s parcel=%h mode16=%0d valid=%0d actual=%h expected=%h",
                     tag, p, m16, out_valid, actual_vec(), exp_v);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [37:0] prev_exp;
        logic [15:0] prev_p;
        bit          prev_m;
        string       prev_tag;
        bit          have_prev;
        string       tg;
        have_prev = 1'b0;
        prev_exp  = '0;
        prev_p    = '0;
        prev_m    = 1'b0;
        prev_tag  = "";

        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || actual_vec() !== 38'd0) begin
            bad++;
            $display("FAIL R1 reset state actual=%h/%0d expected=0/0", actual_vec(), out_valid);
        end
        rst_n = 1'b1;

        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 65536; i++) begin
                @(negedge clk);
                if (have_prev) check_vec(prev_tag, prev_p, prev_m, prev_exp);
                in_valid  = 1'b1;
                in_parcel = i[15:0];
                in_mode16 = m[0];
                prev_p    = i[15:0];
                prev_m    = m[0];
                prev_exp  = model(i[15:0], m[0], tg);
                prev_tag  = tg;
                have_prev = 1'b1;
            end
        end
        @(negedge clk);
        check_vec(prev_tag, prev_p, prev_m, prev_exp);

        // R1: strobe low, new parcel must not be captured
        in_valid  = 1'b0;
        in_parcel = 16'h0A05;
        in_mode16 = 1'b0;
        repeat (2) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || actual_vec() !== prev_exp) begin
            bad++;
            $display("FAIL R1 hold while idle actual=%h/%0d expected=%h/0",
                     actual_vec(), out_valid, prev_exp);
        end

        // R1: a single strobe after idle is captured again
        in_valid  = 1'b1;
        in_parcel = 16'h0249;
        in_mode16 = 1'b1;
        prev_exp  = model(16'h0249, 1'b1, tg);
        @(negedge clk);
        in_valid = 1'b0;
        check_vec({"R1 ", tg}, 16'h0249, 1'b1, prev_exp);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule